// File: doc/BRIEF.md
# Page Descriptor Resolution Engine

This block resolves one page-level descriptor for an address translation unit. Given the byte address of a descriptor, it reads the descriptor over a simple word-wide memory port and classifies it by its two-bit type field. A resident descriptor becomes a translation fill record. An invalid descriptor becomes a fault. An indirect descriptor causes one more read at the address it carries.

For write-type accesses, the block keeps the page's modified flag up to date. If the flag is clear, the block sets it and stores the updated descriptor back to the word it was read from. This happens before completion is signalled, so the access is only granted after the page is marked as written.

The upper table walk, the translation cache array and the data cache are outside this block. The caller starts a resolution with a one-cycle request and waits for a one-cycle completion pulse.

Top module: `pgdesc_resolver`

## Requirements
- R1: After reset the block holds `mem_req_o`, `done_o`, `fill_valid_o` and `fault_o` low. A resolution starts only when `start_i` is high while the block is idle. The low two bits of `start_addr_i` are ignored and the fetch address has them cleared.
- R2: A descriptor whose type bits [1:0] are 00 ends the resolution with `fault_o` high and `fault_kind_o` = 0. No fill record is produced, and nothing is written to memory, whatever the other descriptor bits hold.
- R3: A descriptor whose type bits are 01 or 11 produces a fill record. `fill_desc_o` is the descriptor (with the modified flag as updated), `fill_global_o` is bit 10, and `fill_cmode_o` is bits [6:5]. The cache mode codes are: 00 cachable writethrough, 01 cachable copyback, 10 inhibited precise, 11 inhibited imprecise.
- R4: A first-level descriptor with type 10 causes a second read at its bits [31:2] with bits [1:0] cleared. The descriptor found there is then resolved in place of the pointer.
- R5: A descriptor reached through an indirect pointer that itself has type 10 ends with `fault_o` high and `fault_kind_o` = 1. No fill record is produced.
- R6: `kind_i` encodes 00 read, 01 write, 10 locked read-modify-write, and 11 read. For a write or locked read-modify-write on a resident descriptor with the modified flag (bit 4) clear and no violation, the block writes the descriptor with bit 4 set. The write goes to the address the resident descriptor was read from, and its acknowledge arrives before `done_o`.
- R7: When `wp_viol_i` or `sup_viol_i` is high at start, no write-back occurs and bit 4 of the fill record is left as read.
- R8: A locked read-modify-write access sets the modified flag exactly as a write does.
- R9: Read accesses, and accesses to descriptors whose modified flag is already set, cause no memory write. Every memory write carries bit 4 set.
- R10: `done_o` is high for exactly one cycle per resolution. `fill_valid_o` and `fault_o` are only high in that cycle, and never both together.
- R11: A memory request stays asserted, with stable address, direction and write data, until `mem_ack_i` is seen. Every request address is word aligned.
- R12: `start_i` is ignored while a resolution is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a resolution (sampled when idle) |
| start_addr_i | input | AW | Byte address of the page descriptor |
| kind_i | input | 2 | Access kind: 00 read, 01 write, 10 locked RMW, 11 read |
| wp_viol_i | input | 1 | Write-protect violation from permission check |
| sup_viol_i | input | 1 | Supervisor violation from permission check |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Word-aligned request address |
| mem_wdata_o | output | DW | Write data |
| mem_ack_i | input | 1 | Request accepted; read data valid this cycle |
| mem_rdata_i | input | DW | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Completion is a fault |
| fault_kind_o | output | 1 | 0 invalid type, 1 indirect to indirect |
| fill_valid_o | output | 1 | Completion carries a fill record |
| fill_desc_o | output | DW | Resolved descriptor after flag update |
| fill_global_o | output | 1 | Global flag of the resolved page |
| fill_cmode_o | output | 2 | Cache mode of the resolved page |

## Verification
The bench builds the block with its default widths: 32-bit addresses and descriptors, with the flag positions at their defaults. It backs the memory port with a 64-word model whose acknowledge latency cycles through 0, 1 and 2.

With that setup, the bench can sweep every pair of first-level and indirect-target type codes. For each pair it also sweeps all four access kinds, both modified-flag states and all four violation combinations. This exercises every write-back decision and both fault kinds under stalled and unstalled handshakes. A second start pulse is driven during every run to exercise the busy case.

// File: rtl/pgdesc_pkg.sv
package pgdesc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_FETCH_IND,
    ST_WRITEBACK,
    ST_DONE,
    ST_FAULT
  } pgd_state_e;

  typedef enum logic [1:0] {
    CL_INVALID,
    CL_RESIDENT,
    CL_INDIRECT,
    CL_NESTED
  } pgd_class_e;

  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_RMW   = 2'b10,
    KIND_READ2 = 2'b11
  } pgd_kind_e;

  localparam logic FK_INVALID = 1'b0;
  localparam logic FK_NESTED  = 1'b1;

  function automatic logic kind_is_write(input logic [1:0] k);
    return (k == KIND_WRITE) || (k == KIND_RMW);
  endfunction

endpackage

// File: rtl/pgdesc_decode.sv
module pgdesc_decode
  import pgdesc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int M_BIT = 4,
  parameter int G_BIT = 10,
  parameter int CM_LO = 5
) (
  input  logic [DW-1:0] desc_i,
  input  logic          second_i,
  input  logic          is_write_i,
  input  logic          viol_i,
  output pgd_class_e    cls_o,
  output logic          need_wb_o,
  output logic [DW-1:0] upd_o,
  output logic [AW-1:0] ptr_o,
  output logic          global_o,
  output logic [1:0]    cmode_o
);
  localparam logic [AW-1:0] WORD_MASK = ~AW'(3);

  always_comb begin
    unique case (desc_i[1:0])
      2'b00:   cls_o = CL_INVALID;
      2'b10:   cls_o = second_i ? CL_NESTED : CL_INDIRECT;
      default: cls_o = CL_RESIDENT;
    endcase
  end

  assign need_wb_o = (cls_o == CL_RESIDENT) && is_write_i && !viol_i && !desc_i[M_BIT];

  always_comb begin
    upd_o = desc_i;
    if (need_wb_o) upd_o[M_BIT] = 1'b1;
  end

  assign ptr_o    = desc_i[AW-1:0] & WORD_MASK;
  assign global_o = desc_i[G_BIT];
  assign cmode_o  = desc_i[CM_LO +: 2];

endmodule

// File: rtl/pgdesc_memport.sv
module pgdesc_memport #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int M_BIT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_i,
  input  logic          issue_we_i,
  input  logic [AW-1:0] issue_addr_i,
  input  logic [DW-1:0] issue_wdata_i,
  input  logic          mem_ack_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else if (issue_i) begin
      mem_req_o   <= 1'b1;
      mem_we_o    <= issue_we_i;
      mem_addr_o  <= issue_addr_i;
      mem_wdata_o <= issue_wdata_i;
    end else if (mem_ack_i) begin
      mem_req_o <= 1'b0;
      mem_we_o  <= 1'b0;
    end
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                && $stable(mem_wdata_o));

  assert_addr_align_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  assert_write_sets_flag_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && mem_we_o |-> mem_wdata_o[M_BIT]);

endmodule

// File: rtl/pgdesc_ctrl.sv
module pgdesc_ctrl
  import pgdesc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [1:0]    kind_i,
  input  logic          wp_viol_i,
  input  logic          sup_viol_i,
  input  logic          mem_ack_i,
  input  pgd_class_e    cls_i,
  input  logic          need_wb_i,
  input  logic [DW-1:0] upd_i,
  input  logic [AW-1:0] ptr_i,
  input  logic          global_i,
  input  logic [1:0]    cmode_i,
  output logic          second_o,
  output logic          is_write_o,
  output logic          viol_o,
  output logic          issue_o,
  output logic          issue_we_o,
  output logic [AW-1:0] issue_addr_o,
  output logic [DW-1:0] issue_wdata_o,
  output logic          done_o,
  output logic          fault_o,
  output logic          fault_kind_o,
  output logic          fill_valid_o,
  output logic [DW-1:0] fill_desc_o,
  output logic          fill_global_o,
  output logic [1:0]    fill_cmode_o
);
  localparam logic [AW-1:0] WORD_MASK = ~AW'(3);

  pgd_state_e    state_q, state_n;
  logic [AW-1:0] cur_addr_q;
  logic          is_wr_q, viol_q;
  logic          latch, cap, fin_ok, fin_fault, fkind;

  assign second_o   = (state_q == ST_FETCH_IND);
  assign is_write_o = is_wr_q;
  assign viol_o     = viol_q;

  always_comb begin
    state_n       = state_q;
    issue_o       = 1'b0;
    issue_we_o    = 1'b0;
    issue_addr_o  = cur_addr_q;
    issue_wdata_o = upd_i;
    latch         = 1'b0;
    cap           = 1'b0;
    fin_ok        = 1'b0;
    fin_fault     = 1'b0;
    fkind         = FK_INVALID;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          latch        = 1'b1;
          issue_o      = 1'b1;
          issue_addr_o = start_addr_i & WORD_MASK;
          state_n      = ST_FETCH;
        end
      end
      ST_FETCH, ST_FETCH_IND: begin
        if (mem_ack_i) begin
          unique case (cls_i)
            CL_INDIRECT: begin
              issue_o      = 1'b1;
              issue_addr_o = ptr_i;
              state_n      = ST_FETCH_IND;
            end
            CL_RESIDENT: begin
              cap = 1'b1;
              if (need_wb_i) begin
                issue_o    = 1'b1;
                issue_we_o = 1'b1;
                state_n    = ST_WRITEBACK;
              end else begin
                fin_ok  = 1'b1;
                state_n = ST_DONE;
              end
            end
            CL_NESTED: begin
              fin_fault = 1'b1;
              fkind     = FK_NESTED;
              state_n   = ST_FAULT;
            end
            default: begin
              fin_fault = 1'b1;
              state_n   = ST_FAULT;
            end
          endcase
        end
      end
      ST_WRITEBACK: begin
        if (mem_ack_i) begin
          fin_ok  = 1'b1;
          state_n = ST_DONE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      cur_addr_q    <= '0;
      is_wr_q       <= 1'b0;
      viol_q        <= 1'b0;
      done_o        <= 1'b0;
      fault_o       <= 1'b0;
      fault_kind_o  <= 1'b0;
      fill_valid_o  <= 1'b0;
      fill_desc_o   <= '0;
      fill_global_o <= 1'b0;
      fill_cmode_o  <= 2'b00;
    end else begin
      state_q      <= state_n;
      done_o       <= fin_ok | fin_fault;
      fill_valid_o <= fin_ok;
      fault_o      <= fin_fault;
      if (fin_fault) fault_kind_o <= fkind;
      if (latch) begin
        is_wr_q <= kind_is_write(kind_i);
        viol_q  <= wp_viol_i | sup_viol_i;
      end
      if (issue_o) cur_addr_q <= issue_addr_o;
      if (cap) begin
        fill_desc_o   <= upd_i;
        fill_global_o <= global_i;
        fill_cmode_o  <= cmode_i;
      end
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_fill_fault_excl_R10: assert property (@(posedge clk) disable iff (rst)
    (fill_valid_o || fault_o) |-> done_o && !(fill_valid_o && fault_o));

  assert_wb_before_done_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WRITEBACK) && !mem_ack_i |=> !done_o);

  assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FETCH) && !mem_ack_i |=> state_q == ST_FETCH);

endmodule

// File: rtl/pgdesc_resolver.sv
module pgdesc_resolver
  import pgdesc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int M_BIT = 4,
  parameter int G_BIT = 10,
  parameter int CM_LO = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [1:0]    kind_i,
  input  logic          wp_viol_i,
  input  logic          sup_viol_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic          fault_o,
  output logic          fault_kind_o,
  output logic          fill_valid_o,
  output logic [DW-1:0] fill_desc_o,
  output logic          fill_global_o,
  output logic [1:0]    fill_cmode_o
);

  pgd_class_e    cls;
  logic          need_wb, second, is_write, viol;
  logic [DW-1:0] upd;
  logic [AW-1:0] ptr;
  logic          glob;
  logic [1:0]    cmode;
  logic          issue, issue_we;
  logic [AW-1:0] issue_addr;
  logic [DW-1:0] issue_wdata;

  pgdesc_decode #(.AW(AW), .DW(DW), .M_BIT(M_BIT), .G_BIT(G_BIT), .CM_LO(CM_LO)) u_dec (
    .desc_i     (mem_rdata_i),
    .second_i   (second),
    .is_write_i (is_write),
    .viol_i     (viol),
    .cls_o      (cls),
    .need_wb_o  (need_wb),
    .upd_o      (upd),
    .ptr_o      (ptr),
    .global_o   (glob),
    .cmode_o    (cmode)
  );

  pgdesc_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .start_addr_i  (start_addr_i),
    .kind_i        (kind_i),
    .wp_viol_i     (wp_viol_i),
    .sup_viol_i    (sup_viol_i),
    .mem_ack_i     (mem_ack_i),
    .cls_i         (cls),
    .need_wb_i     (need_wb),
    .upd_i         (upd),
    .ptr_i         (ptr),
    .global_i      (glob),
    .cmode_i       (cmode),
    .second_o      (second),
    .is_write_o    (is_write),
    .viol_o        (viol),
    .issue_o       (issue),
    .issue_we_o    (issue_we),
    .issue_addr_o  (issue_addr),
    .issue_wdata_o (issue_wdata),
    .done_o        (done_o),
    .fault_o       (fault_o),
    .fault_kind_o  (fault_kind_o),
    .fill_valid_o  (fill_valid_o),
    .fill_desc_o   (fill_desc_o),
    .fill_global_o (fill_global_o),
    .fill_cmode_o  (fill_cmode_o)
  );

  pgdesc_memport #(.AW(AW), .DW(DW), .M_BIT(M_BIT)) u_port (
    .clk           (clk),
    .rst           (rst),
    .issue_i       (issue),
    .issue_we_i    (issue_we),
    .issue_addr_i  (issue_addr),
    .issue_wdata_i (issue_wdata),
    .mem_ack_i     (mem_ack_i),
    .mem_req_o     (mem_req_o),
    .mem_we_o      (mem_we_o),
    .mem_addr_o    (mem_addr_o),
    .mem_wdata_o   (mem_wdata_o)
  );

endmodule

// File: tb/pgdesc_resolver_test.sv
module pgdesc_resolver_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] start_addr_i = '0;
  logic [1:0]  kind_i = 2'b00;
  logic        wp_viol_i = 1'b0, sup_viol_i = 1'b0;
  logic        mem_req_o, mem_we_o, mem_ack_i;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        done_o, fault_o, fault_kind_o, fill_valid_o, fill_global_o;
  logic [31:0] fill_desc_o;
  logic [1:0]  fill_cmode_o;

  int checks = 0, errors = 0;

  logic [31:0] mem [64];
  int lat = 0, cnt = 0;
  int nrd = 0, nwr = 0;
  logic [31:0] rd_addr0, rd_addr1, wr_addr;
  logic ack_r = 1'b0;
  logic [31:0] rdata_r = '0;
  assign mem_ack_i   = ack_r;
  assign mem_rdata_i = rdata_r;

  always #10 clk = ~clk;

  pgdesc_resolver uut (
    .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
    .kind_i(kind_i), .wp_viol_i(wp_viol_i), .sup_viol_i(sup_viol_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .done_o(done_o), .fault_o(fault_o), .fault_kind_o(fault_kind_o),
    .fill_valid_o(fill_valid_o), .fill_desc_o(fill_desc_o),
    .fill_global_o(fill_global_o), .fill_cmode_o(fill_cmode_o)
  );

  always @(negedge clk) begin
    if (rst) begin
      ack_r = 1'b0; cnt = 0;
    end else if (ack_r) begin
      ack_r = 1'b0; cnt = 0;
    end else if (mem_req_o) begin
      if (cnt >= lat) begin
        ack_r = 1'b1;
        if (mem_we_o) begin
          mem[mem_addr_o[7:2]] = mem_wdata_o;
          wr_addr = mem_addr_o;
          nwr++;
        end else begin
          rdata_r = mem[mem_addr_o[7:2]];
          if (nrd == 0) rd_addr0 = mem_addr_o; else rd_addr1 = mem_addr_o;
          nrd++;
        end
      end else cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_desc(input int seed, input int ty, input int m,
                                          input int g, input int cm);
    logic [31:0] d;
    d = 32'h5A3C_0000 ^ (32'(seed) * 32'h0001_1088);
    d[1:0] = 2'(ty);
    d[4]   = 1'(m);
    d[6:5] = 2'(cm);
    d[10]  = 1'(g);
    return d;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int run = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 req after reset", 32'(mem_req_o), 0);
    chk("R1 done after reset", 32'(done_o), 0);
    chk("R1 fill_valid after reset", 32'(fill_valid_o), 0);
    chk("R1 fault after reset", 32'(fault_o), 0);

    for (int t1 = 0; t1 < 4; t1++)
    for (int t2 = 0; t2 < 4; t2++) begin
      if (t1 != 2 && t2 != 0) continue;
      for (int k = 0; k < 4; k++)
      for (int m = 0; m < 2; m++)
      for (int v = 0; v < 4; v++) begin
        logic [31:0] d1, d2, dres, exp_desc, res_addr, saddr;
        logic is_wr, wb, exp_fault, exp_fk;
        int waitc;
        run++;
        lat = run % 3;
        for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
        saddr = 32'h10 | 32'(run & 3);
        d2 = mk_desc(run + 7, t2, m, (run >> 1) & 1, (run >> 2) & 3);
        if (t1 == 2) d1 = 32'h0000_00CA;
        else d1 = mk_desc(run, t1, m, run & 1, (run >> 3) & 3);
        mem[4]  = d1;
        mem[50] = d2;
        dres     = (t1 == 2) ? d2 : d1;
        res_addr = (t1 == 2) ? 32'hC8 : 32'h10;
        exp_fault = (t1 == 0) || (t1 == 2 && (t2 == 0 || t2 == 2));
        exp_fk    = (t1 == 2 && t2 == 2);
        is_wr     = (k == 1) || (k == 2);
        wb        = !exp_fault && is_wr && (m == 0) && (v == 0);
        exp_desc  = wb ? (dres | 32'h10) : dres;
        nrd = 0; nwr = 0;
        kind_i = 2'(k); wp_viol_i = v[0]; sup_viol_i = v[1];
        start_addr_i = saddr; start_i = 1'b1;
        @(negedge clk);
        start_addr_i = 32'h20;
        @(negedge clk);
        start_i = 1'b0;
        waitc = 0;
        while (!done_o && waitc < 40) begin @(negedge clk); waitc++; end
        chk("R10 done seen", 32'(done_o), 1);
        chk("R12 first read addr (busy start ignored), R1 low bits", rd_addr0, 32'h10);
        chk(t1 == 2 ? "R4 read count" : "R11 read count", 32'(nrd), (t1 == 2) ? 2 : 1);
        if (t1 == 2) chk("R4 indirect target addr", rd_addr1, 32'hC8);
        chk(exp_fault ? "R2 fault flag" : "R3 fault flag", 32'(fault_o), 32'(exp_fault));
        chk("R10 fill_valid vs fault", 32'(fill_valid_o), 32'(!exp_fault));
        if (exp_fault) begin
          chk(exp_fk ? "R5 fault kind" : "R2 fault kind", 32'(fault_kind_o), 32'(exp_fk));
          chk("R2 no write on fault", 32'(nwr), 0);
        end else begin
          chk(k == 2 ? "R8 fill desc" : (v != 0 ? "R7 fill desc" : "R3 fill desc"),
              fill_desc_o, exp_desc);
          chk("R3 global", 32'(fill_global_o), 32'(dres[10]));
          chk("R3 cmode", 32'(fill_cmode_o), 32'(dres[6:5]));
          chk(wb ? "R6 write count" : "R9 write count", 32'(nwr), wb ? 1 : 0);
          if (wb) begin
            chk("R6 write addr", wr_addr, res_addr);
            chk("R6 stored desc", mem[res_addr[7:2]], exp_desc);
          end else begin
            chk("R9 memory unchanged", mem[res_addr[7:2]], dres);
          end
        end
        @(negedge clk);
        chk("R10 done one cycle", 32'(done_o), 0);
        chk("R10 fill_valid drops", 32'(fill_valid_o), 0);
        @(negedge clk);
      end
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule